// File: doc/BRIEF.md
# Chainable Delay Code Holder

This block is the digital control section of a programmable delay element built to be chained. Each stage holds a delay code in level-sensitive latches that open while a shared latch-enable is high. Two override inputs act directly on those latches. One clears them, which selects the shortest delay. The other sets them all to one, which selects the longest delay. The value held in the latches is the code that reaches the tap-select multiplexers.

Chaining does not add taps to one stage. Each stage takes one extra code bit, the cascade bit. That bit drives a complementary pair of cascade lines, and the pair steers the overrides of the following stage. A low cascade bit pins the next stage at its minimum. A high cascade bit pins it at its maximum. A chain of `STAGES` stages therefore needs an address of `CODE_W + STAGES` bits, one extra line per extra stage. The block also puts out a modelled total chain delay in 10 ps steps, as a combinational sum. The analog delay taps are not part of this block.

Top module: `dly_chain_ctl`

## Requirements
- R1: With `rst_n`, `force_lo` and `force_hi` inactive and `lat_en` high, the first stage's held code (`sel_code[CODE_W-1:0]`) follows `addr[CODE_W-1:0]`.
- R2: While `lat_en` is low, changes on `addr[CODE_W-1:0]` leave the first stage's held code and `total_dly` unchanged.
- R3: While `force_lo` is high, the first stage's held code is all zeros for any `lat_en`. The zeros stay held after `force_lo` falls if `lat_en` is low.
- R4: While `force_hi` is high and `force_lo` is low, the first stage's held code is all ones. The ones stay held after release if `lat_en` is low.
- R5: When `force_lo` and `force_hi` are both high, the clear wins and the held code is all zeros.
- R6: While `rst_n` is low, every stage's held code is all zeros, whatever the overrides and `lat_en` do.
- R7: Stage k (k ≥ 1) sits at `sel_code[k*CODE_W +: CODE_W]`. Its overrides come from the cascade bit of stage k-1, `addr[CODE_W+k-1]`. This bit bypasses the latches. When it is 0, stage k holds all zeros. When it is 1, stage k holds all ones. This holds regardless of `lat_en`.
- R8: `casc_out` equals the last stage's cascade bit `addr[CODE_W+STAGES-1]`, and `casc_out_n` is always its complement.
- R9: `total_dly` equals code0 + Σ over k ≥ 1 of (`FIX_UNITS` + code_k + cascade bit k-1), in 10 ps units. With the defaults this runs from 440 (4400 ps) to 2487 (24870 ps). Stage 1 adds 440 at minimum and 1464 at maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all latches |
| lat_en | input | 1 | Latch enable; latches are transparent while high |
| force_lo | input | 1 | First-stage override to minimum delay (all zeros) |
| force_hi | input | 1 | First-stage override to maximum delay (all ones) |
| addr | input | CODE_W+STAGES | Code bits for stage 0, then one cascade bit per stage |
| sel_code | output | STAGES*CODE_W | Held code of every stage, stage 0 in the low bits |
| casc_out | output | 1 | Cascade line of the last stage, for a following chain |
| casc_out_n | output | 1 | Complement of `casc_out` |
| total_dly | output | TOT_W | Modelled total chain delay in 10 ps units |

## Verification
The bench sweeps every first-stage code against both values of each cascade bit and compares the held codes, the cascade pair and the total with arithmetic references. A mistake in the cascade step, a swapped override polarity or an off-by-one in the maximum contribution shows up there, for example as 1463 where 1464 is due. It checks hold behaviour by changing the address with the latches closed. A latch built as a plain mux would leak the new code. It checks that an override leaves its value behind after release, which a design applying the override only at the output would get wrong. It also asserts both overrides at once, where a design that gives the set priority would return all ones.

// File: rtl/dly_chain_pkg.sv
package dly_chain_pkg;

  // default code width of one stage (bits reaching the tap multiplexers)
  localparam int unsigned DEF_CODE_W = 10;

  // default fixed contribution of a following stage, in 10 ps steps
  localparam int unsigned DEF_FIX_UNITS = 440;

  // override pair applied to a stage's latch bank
  typedef struct packed {
    logic lo;  // clear to minimum
    logic hi;  // set to maximum
  } ovr_t;

endpackage

// File: rtl/dly_latch_bank.sv
module dly_latch_bank #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              rst_n,
  input  logic              lat_en,
  input  dly_chain_pkg::ovr_t ovr,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);

  // one transparent latch per code bit, clear has priority over set
  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    always_latch begin
      if (!rst_n) begin
        q[b] <= 1'b0;
      end else if (ovr.lo) begin
        q[b] <= 1'b0;
      end else if (ovr.hi) begin
        q[b] <= 1'b1;
      end else if (lat_en) begin
        q[b] <= d[b];
      end
    end
  end

  always_comb begin
    // R6
    rst_clear_chk: assert (rst_n !== 1'b0 || q == '0);
    // R3
    lo_clear_chk: assert (rst_n !== 1'b1 || ovr.lo !== 1'b1 || q == '0);
    // R4
    hi_set_chk: assert (rst_n !== 1'b1 || ovr.lo !== 1'b0 || ovr.hi !== 1'b1 || q == '1);
  end

endmodule

// File: rtl/dly_cascade_drv.sv
module dly_cascade_drv (
  input  logic casc_bit,
  output logic casc,
  output logic casc_n
);

  always_comb begin
    casc   = casc_bit;
    casc_n = ~casc_bit;
  end

  always_comb begin
    // R8
    casc_pair_chk: assert (casc_bit === 1'bx || casc != casc_n);
  end

endmodule

// File: rtl/dly_stage.sv
module dly_stage #(
  parameter int unsigned CODE_W = 10
) (
  input  logic                rst_n,
  input  logic                lat_en,
  input  dly_chain_pkg::ovr_t ovr,
  input  logic [CODE_W-1:0]   d,
  input  logic                casc_bit,
  output logic [CODE_W-1:0]   code_q,
  output logic                casc,
  output logic                casc_n
);

  dly_latch_bank #(.CODE_W(CODE_W)) u_bank (
    .rst_n  (rst_n),
    .lat_en (lat_en),
    .ovr    (ovr),
    .d      (d),
    .q      (code_q)
  );

  // the cascade bit is not latched; it steers the next stage directly
  dly_cascade_drv u_casc (
    .casc_bit (casc_bit),
    .casc     (casc),
    .casc_n   (casc_n)
  );

endmodule

// File: rtl/dly_total_model.sv
module dly_total_model #(
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned STAGES    = 2,
  parameter int unsigned FIX_UNITS = 440,
  parameter int unsigned TOT_W     = 12
) (
  input  logic [STAGES*CODE_W-1:0] codes,
  input  logic [STAGES-1:0]        casc_in,
  output logic [TOT_W-1:0]         total
);

  localparam int unsigned TOT_MAX =
    ((1 << CODE_W) - 1) + (STAGES - 1) * (FIX_UNITS + (1 << CODE_W));

  // stage 0 counts from zero; every later stage adds its fixed offset,
  // its held code and one extra step for the cascade carry it receives
  always_comb begin
    total = TOT_W'(codes[CODE_W-1:0]);
    for (int k = 1; k < STAGES; k++) begin
      total = total + TOT_W'(FIX_UNITS)
                    + TOT_W'(codes[k*CODE_W +: CODE_W])
                    + TOT_W'(casc_in[k]);
    end
  end

  always_comb begin
    // R9
    tot_range_chk: assert ($isunknown(total) || 32'(total) <= TOT_MAX);
  end

endmodule

// File: rtl/dly_chain_ctl.sv
module dly_chain_ctl #(
  parameter int unsigned CODE_W    = dly_chain_pkg::DEF_CODE_W,
  parameter int unsigned STAGES    = 2,
  parameter int unsigned FIX_UNITS = dly_chain_pkg::DEF_FIX_UNITS,
  localparam int unsigned ADDR_W   = CODE_W + STAGES,
  localparam int unsigned TOT_MAX  =
    ((1 << CODE_W) - 1) + (STAGES - 1) * (FIX_UNITS + (1 << CODE_W)),
  localparam int unsigned TOT_W    = $clog2(TOT_MAX + 1)
) (
  input  logic                     rst_n,
  input  logic                     lat_en,
  input  logic                     force_lo,
  input  logic                     force_hi,
  input  logic [ADDR_W-1:0]        addr,
  output logic [STAGES*CODE_W-1:0] sel_code,
  output logic                     casc_out,
  output logic                     casc_out_n,
  output logic [TOT_W-1:0]         total_dly
);

  import dly_chain_pkg::*;

  ovr_t              ovr     [STAGES];
  logic [STAGES-1:0] casc_p;
  logic [STAGES-1:0] casc_n;
  logic [STAGES-1:0] casc_in;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [CODE_W-1:0] d_in;

    if (k == 0) begin : g_head
      always_comb begin
        ovr[k].lo  = force_lo;
        ovr[k].hi  = force_hi;
        d_in       = addr[CODE_W-1:0];
        casc_in[k] = 1'b0;
      end
    end else begin : g_tail
      // a following stage is always pinned by its neighbour's cascade pair
      always_comb begin
        ovr[k].lo  = casc_n[k-1];
        ovr[k].hi  = casc_p[k-1];
        d_in       = '0;
        casc_in[k] = casc_p[k-1];
      end

      always_comb begin
        // R7
        tail_pinned_chk: assert (rst_n !== 1'b1 || $isunknown(casc_p[k-1]) ||
          sel_code[k*CODE_W +: CODE_W] == {CODE_W{casc_p[k-1]}});
      end
    end

    dly_stage #(.CODE_W(CODE_W)) u_stage (
      .rst_n    (rst_n),
      .lat_en   (lat_en),
      .ovr      (ovr[k]),
      .d        (d_in),
      .casc_bit (addr[CODE_W+k]),
      .code_q   (sel_code[k*CODE_W +: CODE_W]),
      .casc     (casc_p[k]),
      .casc_n   (casc_n[k])
    );
  end

  always_comb begin
    casc_out   = casc_p[STAGES-1];
    casc_out_n = casc_n[STAGES-1];
  end

  dly_total_model #(
    .CODE_W    (CODE_W),
    .STAGES    (STAGES),
    .FIX_UNITS (FIX_UNITS),
    .TOT_W     (TOT_W)
  ) u_total (
    .codes   (sel_code),
    .casc_in (casc_in),
    .total   (total_dly)
  );

endmodule

// File: tb/tb_dly_chain_ctl.sv
module tb_dly_chain_ctl;

  localparam int CW  = 10;
  localparam int NS  = 2;
  localparam int FIX = 440;
  localparam int AW  = CW + NS;
  localparam int TW  = 12;
  localparam int ONES = (1 << CW) - 1;

  logic          clk;
  logic          rst_n, lat_en, force_lo, force_hi;
  logic [AW-1:0] addr;
  logic [NS*CW-1:0] sel_code;
  logic          casc_out, casc_out_n;
  logic [TW-1:0] total_dly;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  dly_chain_ctl dut (
    .rst_n(rst_n), .lat_en(lat_en), .force_lo(force_lo), .force_hi(force_hi),
    .addr(addr), .sel_code(sel_code), .casc_out(casc_out),
    .casc_out_n(casc_out_n), .total_dly(total_dly)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference total for the two-stage default chain
  function automatic int ref_total(input int c0, input int b10);
    return c0 + FIX + (b10 ? ONES : 0) + b10;
  endfunction

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  function automatic int code0();
    return int'(sel_code[CW-1:0]);
  endfunction

  function automatic int code1();
    return int'(sel_code[2*CW-1:CW]);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    rst_n = 0; lat_en = 1; force_lo = 0; force_hi = 1; addr = '0;
    settle();
    // R6: reset clears both stages even with force_hi set
    chk("R6 code0", code0(), 0);
    chk("R6 code1", code1(), 0);
    force_hi = 0;
    settle();
    chk("R9 reset total", int'(total_dly), FIX);
    rst_n = 1;

    // R1 R7 R8 R9 exhaustive sweep
    for (int c = 0; c <= ONES; c++) begin
      for (int b = 0; b < 4; b++) begin
        addr = AW'(c) | (AW'(b) << CW);
        settle();
        chk("R1 follow", code0(), c);
        chk("R7 tail", code1(), (b & 1) ? ONES : 0);
        chk("R8 casc", int'({casc_out_n, casc_out}), (b >> 1) ? 1 : 2);
        chk("R9 total", int'(total_dly), ref_total(c, b & 1));
      end
    end

    // R2 hold while lat_en low
    for (int i = 0; i < 8; i++) begin
      int held = (i * 173 + 5) & ONES;
      lat_en = 1; addr = AW'(held); settle();
      lat_en = 0; settle();
      addr = AW'((~held) & ONES); settle();
      chk("R2 hold code", code0(), held);
      chk("R2 hold total", int'(total_dly), ref_total(held, 0));
      // R7: cascade bit bypasses the latches
      addr[CW] = 1'b1; settle();
      chk("R7 bypass", code1(), ONES);
    end

    // R3 clear with closed latches, value persists after release
    lat_en = 0; addr = AW'(12'h2A5 & ONES);
    force_lo = 1; settle();
    chk("R3 clear", code0(), 0);
    force_lo = 0; settle();
    chk("R3 persist", code0(), 0);
    lat_en = 1; settle();
    chk("R1 reopen", code0(), 12'h2A5 & ONES);

    // R4 set, persists after release
    addr = AW'(5); force_hi = 1; settle();
    chk("R4 set", code0(), ONES);
    chk("R9 max stage0", int'(total_dly), ref_total(ONES, 0));
    lat_en = 0; force_hi = 0; settle();
    chk("R4 persist", code0(), ONES);

    // R5 both overrides: clear wins
    lat_en = 1; force_lo = 1; force_hi = 1; settle();
    chk("R5 priority", code0(), 0);
    force_lo = 0; force_hi = 0; addr = '1; settle();
    chk("R9 full", int'(total_dly), 2487);

    // R6 reset with closed latches and cascade high
    lat_en = 0; rst_n = 0; settle();
    chk("R6 clear0", code0(), 0);
    chk("R6 clear1", code1(), 0);
    rst_n = 1; settle();
    chk("R7 after reset", code1(), ONES);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule